// File: doc/BRIEF.md
# USB Controller Interrupt Cause Unit

This unit collects every interrupt source of a dual-role USB controller into one latched status vector and one request line. Some sources are raw levels: the VBUS level and the two-wire bus line state. Each passes through a two-flop synchroniser before edge detection. The other sources arrive as single-cycle strobes or level summaries from neighbouring logic: the packet engine, the control-transfer sequencer and the per-pipe buffer status registers.

Each cause has its own detection rule and is gated by the current operating role. Some causes exist only as a host and some only as a peripheral; a cause outside the current role never sets its bit. Software reads `status_o`. It clears chosen bits by writing ones with `clr_we_i`, and it selects which latched causes drive `irq_o` through `irq_en_i`.

Status bit positions (software-visible, fixed): 0 VBUS change, 1 resume, 2 frame refresh, 3 device state, 4 control stage, 5 buffer empty, 6 buffer not ready, 7 buffer ready, 8 bus change, 9 setup acknowledged, 10 setup error. Line-state encoding on `line_state_i`: 2'b10 = J, 2'b01 = K, 2'b00 = SE0.

Top module: `usb_irq_cause_unit`

## Requirements
- R1: Bit 0 sets on both a rising and a falling edge of the synchronised VBUS level. `vbus_lvl_o` shows that synchronised level at all times.
- R2: Synchronised inputs produce no edge from the values they hold when reset is released. A high VBUS or a non-SE0 line state at reset leaves bits 0, 1 and 8 clear.
- R3: Bit 1 sets only in peripheral mode (`host_mode_i`=0) with `suspended_i`=1, when the line state moves from J to K or from J to SE0. Any other transition, any host-mode transition and any transition while not suspended leave bit 1 clear.
- R4: In host mode, bit 2 sets on `sof_sent_i` when `frame_num_i` differs from the frame number of the previous tracked SOF. The first tracked SOF after reset always counts as new.
- R5: In peripheral mode with `sof_mode_i`=0, bit 2 sets on `sof_rcvd_i` with a new frame number. With `sof_mode_i`=1 it sets only on `sof_bad_i`. Strobes of the other kinds leave bit 2 clear.
- R6: Bit 3 sets on any bit of `dev_evt_i` in peripheral mode only.
- R7: Bit 4 sets on any bit of `ctrl_evt_i` in peripheral mode only.
- R8: Bit 9 sets on `setup_ack_i` and bit 10 sets on `setup_err_i`, in host mode only.
- R9: Bits 5, 6 and 7 set, in either mode, whenever any bit of `pipe_bemp_i`, `pipe_nrdy_i` or `pipe_brdy_i` respectively is one.
- R10: Bit 8 sets on any change of the synchronised two-bit line state, in either mode.
- R11: A status bit stays set until a write with `clr_we_i`=1 carries a one in its position in `clr_data_i`. Other bits are unaffected by that write. A set event in the same cycle as its clear leaves the bit set.
- R12: `irq_o` is high exactly when some status bit and its `irq_en_i` bit are both one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_mode_i | input | 1 | 1 = host role, 0 = peripheral role |
| sof_mode_i | input | 1 | Peripheral frame cause select: 0 new frame, 1 corrupted SOF |
| suspended_i | input | 1 | Port is in the suspended state |
| vbus_i | input | 1 | Asynchronous VBUS level |
| line_state_i | input | 2 | Asynchronous bus line state |
| sof_sent_i | input | 1 | Strobe: SOF transmitted |
| sof_rcvd_i | input | 1 | Strobe: valid SOF received |
| sof_bad_i | input | 1 | Strobe: corrupted SOF detected |
| frame_num_i | input | FRAME_W | Frame number qualifying the SOF strobes |
| dev_evt_i | input | 4 | Strobes: bus reset, suspend, set address, set configuration |
| ctrl_evt_i | input | 5 | Strobes: control stage transitions and sequence error |
| setup_ack_i | input | 1 | Strobe: setup transaction acknowledged |
| setup_err_i | input | 1 | Strobe: setup transaction not acknowledged |
| pipe_bemp_i | input | N_PIPE | Per-pipe buffer-empty flags |
| pipe_nrdy_i | input | N_PIPE | Per-pipe not-ready flags |
| pipe_brdy_i | input | N_PIPE | Per-pipe buffer-ready flags |
| irq_en_i | input | 11 | Per-cause interrupt enables |
| clr_we_i | input | 1 | Status clear write strobe |
| clr_data_i | input | 11 | Write-one-to-clear data |
| status_o | output | 11 | Latched cause status |
| vbus_lvl_o | output | 1 | Synchronised VBUS level |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Some behaviour is checked by the embedded assertions on every cycle. They cover status latching and event-over-clear priority, the absence of spurious bit rises, the role gating of host-only and peripheral-only causes, the blocking of corrupted-SOF reporting outside its mode, and the silencing of the request line when all enables are off. Other behaviour depends on history and is shown only by the bench's sweeps. This covers the synchroniser priming after reset and the direction of VBUS edges. It also covers resume qualification across every pairing of line states, suspend flags and roles, and the frame-number comparison across repeated and changed frames. The per-pipe summary for every pipe and the enable sweep over each cause are likewise bench-only.

// File: rtl/usb_irq_pkg.sv
`timescale 1ns/1ps
package usb_irq_pkg;
  localparam int unsigned N_CAUSE    = 11;
  localparam int unsigned N_DEV_EVT  = 4;
  localparam int unsigned N_CTRL_EVT = 5;

  typedef enum int unsigned {
    CS_VBUS   = 0,
    CS_RESUME = 1,
    CS_FRAME  = 2,
    CS_DEVST  = 3,
    CS_CTRL   = 4,
    CS_BEMPTY = 5,
    CS_NRDY   = 6,
    CS_BRDY   = 7,
    CS_BUSCHG = 8,
    CS_SACK   = 9,
    CS_SERR   = 10
  } cause_e;

  typedef logic [N_CAUSE-1:0] cause_vec_t;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_K   = 2'b01;
  localparam logic [1:0] LS_J   = 2'b10;

  localparam cause_vec_t PERIPH_ONLY = cause_vec_t'((1 << CS_RESUME) | (1 << CS_DEVST) | (1 << CS_CTRL));
  localparam cause_vec_t HOST_ONLY   = cause_vec_t'((1 << CS_SACK) | (1 << CS_SERR));
endpackage

// File: rtl/usb_irq_sync.sv
`timescale 1ns/1ps
module usb_irq_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o,
  output logic             primed_o
);
  localparam int unsigned FILL = STAGES + 1;
  localparam int unsigned CW   = $clog2(FILL + 1);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [WIDTH-1:0]             prev_q;
  logic [CW-1:0]                fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      prev_q  <= '0;
      fill_q  <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
      if (fill_q != CW'(FILL)) fill_q <= fill_q + 1'b1;
    end
  end

  // edges count only once prev holds a real sample
  assign sync_o   = stage_q[STAGES-1];
  assign prev_o   = prev_q;
  assign primed_o = (fill_q == CW'(FILL));
endmodule

// File: rtl/usb_irq_frame_det.sv
`timescale 1ns/1ps
module usb_irq_frame_det #(
  parameter int unsigned FRAME_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_mode_i,
  input  logic               sof_mode_i,
  input  logic               sof_sent_i,
  input  logic               sof_rcvd_i,
  input  logic               sof_bad_i,
  input  logic [FRAME_W-1:0] frame_num_i,
  output logic               evt_o
);
  logic [FRAME_W-1:0] last_q;
  logic               have_q;
  logic               track;
  logic               is_new;

  assign track  = host_mode_i ? sof_sent_i : sof_rcvd_i;
  assign is_new = !have_q || (frame_num_i != last_q);

  always_comb begin
    if (host_mode_i)     evt_o = sof_sent_i && is_new;
    else if (sof_mode_i) evt_o = sof_bad_i;
    else                 evt_o = sof_rcvd_i && is_new;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      have_q <= 1'b0;
    end else if (track) begin
      last_q <= frame_num_i;
      have_q <= 1'b1;
    end
  end

  AST_BAD_SOF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((host_mode_i || !sof_mode_i) && !sof_sent_i && !sof_rcvd_i) |-> !evt_o); // R5
  AST_REPEAT_FRAME_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (track && !sof_bad_i) |=> ((track && !sof_bad_i && frame_num_i == $past(frame_num_i)) |-> !evt_o)); // R4
endmodule

// File: rtl/usb_irq_status.sv
`timescale 1ns/1ps
module usb_irq_status #(
  parameter int unsigned N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] clr_hit;
  assign clr_hit = {N{clr_we_i}} & clr_mask_i;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         bit_q <= 1'b0;
      else if (set_i[i])   bit_q <= 1'b1;
      else if (clr_hit[i]) bit_q <= 1'b0;
    end
    assign status_o[i] = bit_q;
  end

  assign irq_o = |(status_o & en_i);

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))); // R11
  AST_HOLD_UNCLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != '0) |=> ((status_o & $past(status_o & ~clr_hit)) == $past(status_o & ~clr_hit))); // R11
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) |=> ((status_o & ~$past(status_o)) == '0)); // R11
endmodule

// File: rtl/usb_irq_cause_unit.sv
`timescale 1ns/1ps
module usb_irq_cause_unit
  import usb_irq_pkg::*;
#(
  parameter int unsigned FRAME_W = 11,
  parameter int unsigned N_PIPE  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  host_mode_i,
  input  logic                  sof_mode_i,
  input  logic                  suspended_i,
  input  logic                  vbus_i,
  input  logic [1:0]            line_state_i,
  input  logic                  sof_sent_i,
  input  logic                  sof_rcvd_i,
  input  logic                  sof_bad_i,
  input  logic [FRAME_W-1:0]    frame_num_i,
  input  logic [N_DEV_EVT-1:0]  dev_evt_i,
  input  logic [N_CTRL_EVT-1:0] ctrl_evt_i,
  input  logic                  setup_ack_i,
  input  logic                  setup_err_i,
  input  logic [N_PIPE-1:0]     pipe_bemp_i,
  input  logic [N_PIPE-1:0]     pipe_nrdy_i,
  input  logic [N_PIPE-1:0]     pipe_brdy_i,
  input  logic [N_CAUSE-1:0]    irq_en_i,
  input  logic                  clr_we_i,
  input  logic [N_CAUSE-1:0]    clr_data_i,
  output logic [N_CAUSE-1:0]    status_o,
  output logic                  vbus_lvl_o,
  output logic                  irq_o
);
  localparam int unsigned SYNC_W = 3;

  logic [SYNC_W-1:0] s_now, s_prev;
  logic              primed;
  logic [1:0]        ls_now, ls_prev;
  logic              vbus_chg, ls_chg, resume_hit, frame_evt;
  logic              is_periph;
  cause_vec_t        set_vec;

  usb_irq_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({vbus_i, line_state_i}),
    .sync_o  (s_now),
    .prev_o  (s_prev),
    .primed_o(primed)
  );

  assign ls_now     = s_now[1:0];
  assign ls_prev    = s_prev[1:0];
  assign vbus_chg   = primed && (s_now[2] != s_prev[2]);
  assign ls_chg     = primed && (ls_now != ls_prev);
  assign is_periph  = !host_mode_i;
  assign resume_hit = is_periph && suspended_i && ls_chg && (ls_prev == LS_J) &&
                      ((ls_now == LS_K) || (ls_now == LS_SE0));

  usb_irq_frame_det #(.FRAME_W(FRAME_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_mode_i(host_mode_i),
    .sof_mode_i (sof_mode_i),
    .sof_sent_i (sof_sent_i),
    .sof_rcvd_i (sof_rcvd_i),
    .sof_bad_i  (sof_bad_i),
    .frame_num_i(frame_num_i),
    .evt_o      (frame_evt)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[CS_VBUS]   = vbus_chg;
    set_vec[CS_RESUME] = resume_hit;
    set_vec[CS_FRAME]  = frame_evt;
    set_vec[CS_DEVST]  = is_periph && (dev_evt_i != '0);
    set_vec[CS_CTRL]   = is_periph && (ctrl_evt_i != '0);
    set_vec[CS_BEMPTY] = |pipe_bemp_i;
    set_vec[CS_NRDY]   = |pipe_nrdy_i;
    set_vec[CS_BRDY]   = |pipe_brdy_i;
    set_vec[CS_BUSCHG] = ls_chg;
    set_vec[CS_SACK]   = host_mode_i && setup_ack_i;
    set_vec[CS_SERR]   = host_mode_i && setup_err_i;
  end

  usb_irq_status #(.N(N_CAUSE)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .clr_we_i  (clr_we_i),
    .clr_mask_i(clr_data_i),
    .en_i      (irq_en_i),
    .status_o  (status_o),
    .irq_o     (irq_o)
  );

  assign vbus_lvl_o = s_now[2];

  AST_HOST_BLOCKS_PERIPH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && ((status_o & PERIPH_ONLY) == '0)) |=> ((status_o & PERIPH_ONLY) == '0)); // R6
  AST_PERIPH_BLOCKS_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && ((status_o & HOST_ONLY) == '0)) |=> ((status_o & HOST_ONLY) == '0)); // R8
  AST_RESUME_NEEDS_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!suspended_i && !status_o[CS_RESUME]) |=> !status_o[CS_RESUME]); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o); // R12
endmodule

// File: tb/usb_irq_cause_unit_tb_top.sv
`timescale 1ns/1ps
module usb_irq_cause_unit_tb_top;
  import usb_irq_pkg::*;

  localparam int unsigned FRAME_W = 11;
  localparam int unsigned N_PIPE  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic host_mode, sof_mode, suspended, vbus;
  logic [1:0] line;
  logic sof_sent, sof_rcvd, sof_bad;
  logic [FRAME_W-1:0] frame;
  logic [N_DEV_EVT-1:0] dev_evt;
  logic [N_CTRL_EVT-1:0] ctrl_evt;
  logic setup_ack, setup_err;
  logic [N_PIPE-1:0] bemp, nrdy, brdy;
  logic [N_CAUSE-1:0] irq_en, clr_data;
  logic clr_we;
  logic [N_CAUSE-1:0] status;
  logic vbus_lvl, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  usb_irq_cause_unit #(.FRAME_W(FRAME_W), .N_PIPE(N_PIPE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_mode_i(host_mode), .sof_mode_i(sof_mode),
    .suspended_i(suspended), .vbus_i(vbus), .line_state_i(line),
    .sof_sent_i(sof_sent), .sof_rcvd_i(sof_rcvd), .sof_bad_i(sof_bad),
    .frame_num_i(frame), .dev_evt_i(dev_evt), .ctrl_evt_i(ctrl_evt),
    .setup_ack_i(setup_ack), .setup_err_i(setup_err),
    .pipe_bemp_i(bemp), .pipe_nrdy_i(nrdy), .pipe_brdy_i(brdy),
    .irq_en_i(irq_en), .clr_we_i(clr_we), .clr_data_i(clr_data),
    .status_o(status), .vbus_lvl_o(vbus_lvl), .irq_o(irq)
  );

  function automatic logic [31:0] bit_of(input int i);
    return 32'(1) << i;
  endfunction

  function automatic logic [1:0] ls_code(input int k);
    case (k)
      0:       return LS_J;
      1:       return LS_K;
      default: return LS_SE0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_data = '1; clr_we = 1'b1; step(1);
    clr_we = 1'b0; clr_data = '0; step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    logic [FRAME_W-1:0] m_last;
    bit m_have;
    rst_n = 1'b0; host_mode = 1'b0; sof_mode = 1'b0; suspended = 1'b0;
    vbus = 1'b1; line = LS_J; sof_sent = 0; sof_rcvd = 0; sof_bad = 0; frame = '0;
    dev_evt = '0; ctrl_evt = '0; setup_ack = 0; setup_err = 0;
    bemp = '0; nrdy = '0; brdy = '0; irq_en = '0; clr_we = 0; clr_data = '0;
    step(3);
    rst_n = 1'b1;
    step(6);
    // R2: first samples after reset give no edge
    check("R2 reset status", 32'(status), 0);
    check("R1 vbus level", 32'(vbus_lvl), 1);
    check("R12 irq at reset", 32'(irq), 0);

    // R1: both VBUS edges
    vbus = 1'b0; step(4);
    check("R1 vbus falling", 32'(status), bit_of(CS_VBUS));
    check("R1 vbus level low", 32'(vbus_lvl), 0);
    clear_all();
    check("R11 clear all", 32'(status), 0);
    vbus = 1'b1; step(4);
    check("R1 vbus rising", 32'(status), bit_of(CS_VBUS));
    clear_all();

    // R3 R10: resume and bus change sweep
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3; b++)
            if (a != b) begin
              host_mode = m[0]; suspended = s[0];
              line = ls_code(a); step(4); clear_all();
              line = ls_code(b); step(4);
              exp = bit_of(CS_BUSCHG);
              if (m == 0 && s == 1 && a == 0 && b != 0) exp |= bit_of(CS_RESUME);
              check($sformatf("R3 R10 line %0d->%0d host %0d susp %0d", a, b, m, s),
                    32'(status), exp);
              clear_all();
            end
    suspended = 1'b0;

    // R4 R5: frame refresh
    m_have = 0; m_last = '0;
    for (int cfg = 0; cfg < 4; cfg++) begin
      host_mode = (cfg >= 2); sof_mode = cfg[0];
      for (int kind = 0; kind < 3; kind++)
        for (int rep = 0; rep < 2; rep++) begin
          logic [FRAME_W-1:0] f;
          bit hit, trk;
          f = FRAME_W'(cfg * 8 + kind);
          frame = f;
          if (kind == 0) sof_sent = 1'b1;
          else if (kind == 1) sof_rcvd = 1'b1;
          else sof_bad = 1'b1;
          step(1);
          sof_sent = 0; sof_rcvd = 0; sof_bad = 0;
          step(1);
          if (host_mode) hit = (kind == 0) && (!m_have || f != m_last);
          else if (sof_mode) hit = (kind == 2);
          else hit = (kind == 1) && (!m_have || f != m_last);
          trk = host_mode ? (kind == 0) : (kind == 1);
          if (trk) begin m_last = f; m_have = 1; end
          check($sformatf("R4 R5 frame cfg %0d kind %0d rep %0d", cfg, kind, rep),
                32'(status), hit ? bit_of(CS_FRAME) : 0);
          clear_all();
        end
    end
    sof_mode = 1'b0;

    // R6 R7 R8: role-restricted strobes
    for (int m = 0; m < 2; m++) begin
      host_mode = m[0];
      for (int i = 0; i < N_DEV_EVT; i++) begin
        dev_evt = N_DEV_EVT'(1 << i); step(1); dev_evt = '0; step(1);
        check($sformatf("R6 dev evt %0d host %0d", i, m), 32'(status), m == 0 ? bit_of(CS_DEVST) : 0);
        clear_all();
      end
      for (int i = 0; i < N_CTRL_EVT; i++) begin
        ctrl_evt = N_CTRL_EVT'(1 << i); step(1); ctrl_evt = '0; step(1);
        check($sformatf("R7 ctrl evt %0d host %0d", i, m), 32'(status), m == 0 ? bit_of(CS_CTRL) : 0);
        clear_all();
      end
      setup_ack = 1'b1; step(1); setup_ack = 1'b0; step(1);
      check($sformatf("R8 setup ack host %0d", m), 32'(status), m == 1 ? bit_of(CS_SACK) : 0);
      clear_all();
      setup_err = 1'b1; step(1); setup_err = 1'b0; step(1);
      check($sformatf("R8 setup err host %0d", m), 32'(status), m == 1 ? bit_of(CS_SERR) : 0);
      clear_all();
    end

    // R9: per-pipe summaries
    for (int m = 0; m < 2; m++) begin
      host_mode = m[0];
      for (int p = 0; p < N_PIPE; p++)
        for (int k = 0; k < 3; k++) begin
          if (k == 0) bemp[p] = 1'b1;
          else if (k == 1) nrdy[p] = 1'b1;
          else brdy[p] = 1'b1;
          step(1);
          bemp = '0; nrdy = '0; brdy = '0;
          step(1);
          check($sformatf("R9 pipe %0d kind %0d host %0d", p, k, m), 32'(status), bit_of(CS_BEMPTY + k));
          clear_all();
        end
    end

    // R11: event beats clear, latched hold, selective clear
    host_mode = 1'b1;
    setup_ack = 1'b1; clr_we = 1'b1; clr_data = N_CAUSE'(bit_of(CS_SACK));
    step(1);
    setup_ack = 1'b0; clr_we = 1'b0; clr_data = '0;
    step(1);
    check("R11 event wins over clear", 32'(status), bit_of(CS_SACK));
    setup_err = 1'b1; step(1); setup_err = 1'b0; step(5);
    check("R11 latched hold", 32'(status), bit_of(CS_SACK) | bit_of(CS_SERR));
    clr_we = 1'b1; clr_data = N_CAUSE'(bit_of(CS_SACK)); step(1);
    clr_we = 1'b0; clr_data = '0; step(1);
    check("R11 selective clear", 32'(status), bit_of(CS_SERR));
    clr_we = 1'b0; clr_data = '1; step(2);
    check("R11 data without strobe", 32'(status), bit_of(CS_SERR));
    clr_data = '0;

    // R12: enable sweep
    bemp[0] = 1'b1; step(1); bemp = '0; step(1);
    exp = bit_of(CS_SERR) | bit_of(CS_BEMPTY);
    check("R12 setup status", 32'(status), exp);
    for (int i = 0; i < N_CAUSE; i++) begin
      irq_en = N_CAUSE'(1 << i); step(1);
      check($sformatf("R12 irq en bit %0d", i), 32'(irq), (exp >> i) & 1);
    end
    irq_en = '0; step(1);
    check("R12 irq all disabled", 32'(irq), 0);
    irq_en = '1; step(1);
    check("R12 irq all enabled", 32'(irq), 1);
    clear_all();
    check("R12 irq after clear", 32'(irq), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule